// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This block keeps the status byte of a serial flash memory and decides, for every write-type command, whether the command may go ahead. The command decoder hands it one decoded operation per selection, with the target address and the status data byte. The block also watches the chip-select line, the write-protect pin, and the busy and done signals of the internal write timer. A command takes effect when chip select rises. An accepted program, erase or status write gives a one-cycle start pulse to the write timer. A rejected command is dropped without a trace.

The status byte combines a write-enable latch, two block-protect bits, a hardware-protect enable bit and the busy flag. The block-protect bits choose how much of the top of the array is read-only: nothing, the top quarter, the top half or the whole array. The lockout range is output so that neighbouring logic can use it. Level permit outputs tell at any time whether an array write at the current address, or a status write, would be accepted.

Top module: `sr_protect_unit`

## Requirements
- R1: After reset the write-enable latch is 0, and the block-protect bits and protect-enable bit hold their parameter values (default 0). With the default parameters the status byte reads 0x00.
- R2: When idle, the status byte is {enable, 3'b000, bp[1], bp[0], latch, 1'b0}. Bit 7 is the protect enable, bits 3:2 are the protect level and bit 1 is the write-enable latch.
- R3: While busy_in is high, the status byte reads 0xFF.
- R4: Command codes are 1 = write enable, 2 = write disable, 3 = status write, 4 = program, 5 = sector erase and 6 = chip erase. Codes 1 and 2 set or clear the latch when chip select rises, whatever the level of wp_n.
- R5: A done_in pulse clears the write-enable latch.
- R6: The protect level selects the lockout range on lock_lo and lock_any. Level 0 locks nothing. Level 1 locks from 3/4 of the array to the top (0x18000 for 17 address bits). Level 2 locks from the midpoint (0x10000). Level 3 locks from address 0.
- R7: A program or sector erase is accepted (arr_start) only when the latch is set and the address lies below lock_lo, or no lock is active. A chip erase is accepted only when the latch is set and the level is not 3.
- R8: A status write is accepted (sr_start) only when the latch is set and hardware protection is inactive. It loads only bit 7 and bits 3:2 from the data byte.
- R9: Hardware protection is active only when wp_n is 0 and the protect enable is 1. With the enable at 0, a low wp_n blocks nothing.
- R10: If hardware protection becomes active at any clock while a status write is selected, that write is cancelled, even if wp_n returns high before chip select rises.
- R11: Commands strobed or completed while busy_in is high are ignored.
- R12: arr_wr_ok shows whether a program at cmd_addr would now be accepted. sr_wr_ok shows whether a status write would now be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low; a rising edge completes the command |
| cmd_stb | input | 1 | One-cycle strobe of a decoded command |
| cmd_op | input | 3 | Command code (see R4) |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_in | input | 1 | Internal write cycle in progress |
| done_in | input | 1 | Internal write cycle completed |
| status | output | 8 | Status byte |
| arr_wr_ok | output | 1 | Array write at cmd_addr would be accepted now |
| sr_wr_ok | output | 1 | Status write would be accepted now |
| lock_lo | output | ADDR_W | Lowest locked address |
| lock_any | output | 1 | Some part of the array is locked |
| arr_start | output | 1 | Pulse: array write or erase accepted |
| sr_start | output | 1 | Pulse: status write accepted |

## Verification
A latch stuck at the wrong value shows at status bit 1 in the cycle after the chip-select rise or done pulse that should have moved it. It also changes arr_start or sr_start in the next write command. A wrong protect level or enable bit shows at once on lock_lo, lock_any and the level permits. It also turns an accepted write into a rejected one, or the other way round, at the very next commit. A lost cancel flag only shows as an unexpected sr_start in the cycle after chip select rises. For this reason the bench drives a short low pulse on the pin in the middle of a selection.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WREN   = 3'd1,
        OP_WRDI   = 3'd2,
        OP_WRSR   = 3'd3,
        OP_PROG   = 3'd4,
        OP_SERASE = 3'd5,
        OP_CERASE = 3'd6
    } sr_op_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
        logic       wen;
    } sr_state_t;

    typedef struct packed {
        logic arr;
        logic sr;
    } sr_go_t;

    function automatic logic [7:0] pack_status(input logic busy, input sr_state_t s);
        if (busy) return 8'hFF;
        return {s.wpen, 3'b000, s.bp, s.wen, 1'b0};
    endfunction

    function automatic logic is_addressed_write(input sr_op_e op);
        return (op == OP_PROG) || (op == OP_SERASE);
    endfunction

endpackage

// File: rtl/sr_cmd_track.sv
module sr_cmd_track
    import sr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              cmd_stb,
    input  sr_op_e            cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              hw_prot,
    input  logic              busy_in,
    output logic              commit,
    output sr_op_e            pend_op,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [7:0]        pend_data,
    output logic              pend_cancel
);
    logic sel_q;

    assign commit = sel_n && !sel_q && !busy_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q       <= 1'b1;
            pend_op     <= OP_NONE;
            pend_addr   <= '0;
            pend_data   <= '0;
            pend_cancel <= 1'b0;
        end else begin
            sel_q <= sel_n;
            if (sel_n) begin
                pend_op     <= OP_NONE;
                pend_cancel <= 1'b0;
            end else if (cmd_stb && !busy_in) begin
                pend_op     <= cmd_op;
                pend_addr   <= cmd_addr;
                pend_data   <= cmd_data;
                pend_cancel <= 1'b0;
            end else if (pend_op == OP_WRSR && hw_prot) begin
                pend_cancel <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sr_lock_decode.sv
module sr_lock_decode #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] lock_lo,
    output logic              lock_any,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LO_QUARTER = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] LO_HALF    = {1'b1, {(ADDR_W-1){1'b0}}};

    always_comb begin
        case (bp)
            2'd1:    lock_lo = LO_QUARTER;
            2'd2:    lock_lo = LO_HALF;
            default: lock_lo = '0;
        endcase
        lock_any = (bp != 2'd0);
        hit      = lock_any && (addr >= lock_lo);
    end
endmodule

// File: rtl/sr_regs.sv
module sr_regs
    import sr_pkg::*;
#(
    parameter logic [1:0] RST_BP   = 2'b00,
    parameter logic       RST_WPEN = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  sr_op_e     pend_op,
    input  logic [7:0] pend_data,
    input  logic       pend_cancel,
    input  logic       pend_hit,
    input  logic       hw_prot,
    input  logic       done_in,
    output sr_state_t  st,
    output sr_go_t     go
);
    logic acc_sr, acc_arr;

    always_comb begin
        acc_sr  = commit && (pend_op == OP_WRSR) && st.wen && !hw_prot && !pend_cancel;
        acc_arr = commit && st.wen &&
                  ((is_addressed_write(pend_op) && !pend_hit) ||
                   (pend_op == OP_CERASE && st.bp != 2'b11));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.wen  <= 1'b0;
            st.bp   <= RST_BP;
            st.wpen <= RST_WPEN;
            go      <= '0;
        end else begin
            go.arr <= acc_arr;
            go.sr  <= acc_sr;
            if (acc_sr) begin
                st.wpen <= pend_data[7];
                st.bp   <= pend_data[3:2];
            end
            if (done_in)
                st.wen <= 1'b0;
            else if (commit && pend_op == OP_WREN)
                st.wen <= 1'b1;
            else if (commit && pend_op == OP_WRDI)
                st.wen <= 1'b0;
        end
    end
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
    import sr_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter logic [1:0] RST_BP   = 2'b00,
    parameter logic       RST_WPEN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              cmd_stb,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    input  logic              busy_in,
    input  logic              done_in,
    output logic [7:0]        status,
    output logic              arr_wr_ok,
    output logic              sr_wr_ok,
    output logic [ADDR_W-1:0] lock_lo,
    output logic              lock_any,
    output logic              arr_start,
    output logic              sr_start
);
    sr_state_t         st;
    sr_go_t            go;
    sr_op_e            pend_op;
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0]        pend_data;
    logic              pend_cancel, commit, hw_prot;
    logic              hit_now, hit_pend, any_pend;
    logic [ADDR_W-1:0] lo_pend;
    logic              wen_q, wpen_q;
    logic [1:0]        bp_q;

    assign hw_prot = !wp_n && st.wpen;
    assign wen_q   = st.wen;
    assign wpen_q  = st.wpen;
    assign bp_q    = st.bp;

    sr_cmd_track #(.ADDR_W(ADDR_W)) u_track (
        .clk(clk), .rst(rst), .sel_n(sel_n), .cmd_stb(cmd_stb),
        .cmd_op(sr_op_e'(cmd_op)), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .hw_prot(hw_prot), .busy_in(busy_in), .commit(commit),
        .pend_op(pend_op), .pend_addr(pend_addr), .pend_data(pend_data),
        .pend_cancel(pend_cancel)
    );

    sr_lock_decode #(.ADDR_W(ADDR_W)) u_lock_now (
        .bp(st.bp), .addr(cmd_addr), .lock_lo(lock_lo),
        .lock_any(lock_any), .hit(hit_now)
    );

    sr_lock_decode #(.ADDR_W(ADDR_W)) u_lock_pend (
        .bp(st.bp), .addr(pend_addr), .lock_lo(lo_pend),
        .lock_any(any_pend), .hit(hit_pend)
    );

    sr_regs #(.RST_BP(RST_BP), .RST_WPEN(RST_WPEN)) u_regs (
        .clk(clk), .rst(rst), .commit(commit), .pend_op(pend_op),
        .pend_data(pend_data), .pend_cancel(pend_cancel), .pend_hit(hit_pend),
        .hw_prot(hw_prot), .done_in(done_in), .st(st), .go(go)
    );

    assign status    = pack_status(busy_in, st);
    assign arr_wr_ok = st.wen && !busy_in && !hit_now;
    assign sr_wr_ok  = st.wen && !busy_in && !hw_prot;
    assign arr_start = go.arr;
    assign sr_start  = go.sr;
endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       busy_in,
    input logic       done_in,
    input logic [7:0] status,
    input logic       wen_q,
    input logic [1:0] bp_q,
    input logic       wpen_q,
    input logic       arr_start,
    input logic       sr_start
);
    assert_idle_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !busy_in |-> status[6:4] == 3'b000);

    assert_busy_all_ones_R3: assert property (@(posedge clk) disable iff (rst)
        busy_in |-> status == 8'hFF);

    assert_done_clears_latch_R5: assert property (@(posedge clk) disable iff (rst)
        done_in |=> !wen_q);

    assert_arr_needs_latch_R7: assert property (@(posedge clk) disable iff (rst)
        arr_start |-> $past(wen_q));

    assert_sr_fields_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !sr_start |-> $stable({wpen_q, bp_q}));

    assert_sr_not_hw_locked_R9: assert property (@(posedge clk) disable iff (rst)
        sr_start |-> !($past(!wp_n) && $past(wpen_q)));

    assert_no_start_when_busy_R11: assert property (@(posedge clk) disable iff (rst)
        $past(busy_in) |-> !arr_start && !sr_start);
endmodule

bind sr_protect_unit sr_protect_chk u_chk (
    .clk(clk), .rst(rst), .wp_n(wp_n), .busy_in(busy_in), .done_in(done_in),
    .status(status), .wen_q(wen_q), .bp_q(bp_q), .wpen_q(wpen_q),
    .arr_start(arr_start), .sr_start(sr_start)
);

// File: tb/tb_sr_protect_unit.sv
module tb_sr_protect_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sel_n = 1'b1, cmd_stb = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = '0;
    logic              wp_n = 1'b1, busy_in = 1'b0, done_in = 1'b0;
    logic [7:0]        status;
    logic              arr_wr_ok, sr_wr_ok, lock_any, arr_start, sr_start;
    logic [ADDR_W-1:0] lock_lo;

    sr_protect_unit #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .busy_in(busy_in),
        .done_in(done_in), .status(status), .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok),
        .lock_lo(lock_lo), .lock_any(lock_any), .arr_start(arr_start), .sr_start(sr_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // what each scoreboard item compares against
    localparam int S_STATUS = 0, S_GO = 1, S_LOLO = 2, S_LANY = 3, S_AOK = 4, S_SOK = 5;

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event  obs_ev;
    int    n_checks = 0, n_fail = 0;
    bit    done_run = 0;

    // monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            @(obs_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    S_STATUS: act = 32'(status);
                    S_GO:     act = {30'd0, arr_start, sr_start};
                    S_LOLO:   act = 32'(lock_lo);
                    S_LANY:   act = {31'd0, lock_any};
                    S_AOK:    act = {31'd0, arr_wr_ok};
                    default:  act = {31'd0, sr_wr_ok};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input string tag, input int sel, input logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic observe();
        ->obs_ev;
        #1;
    endtask

    // one selection; ends in the cycle after the chip-select rise has been clocked
    task automatic txn(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [7:0] d, input bit wp_glitch);
        @(negedge clk) sel_n = 1'b0;
        @(negedge clk) begin cmd_stb = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; end
        @(negedge clk) begin cmd_stb = 1'b0; if (wp_glitch) wp_n = 1'b0; end
        @(negedge clk) if (wp_glitch) wp_n = 1'b1;
        @(negedge clk) sel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic txn_chk(input string tag, input logic [2:0] op, input logic [ADDR_W-1:0] a,
                           input logic [7:0] d, input bit wp_glitch,
                           input logic [1:0] exp_go, input logic [7:0] exp_st);
        txn(op, a, d, wp_glitch);
        expect_item(tag, S_GO, 32'(exp_go));
        expect_item(tag, S_STATUS, 32'(exp_st));
        observe();
    endtask

    // internal cycle: busy high, done pulse, busy low
    task automatic write_cycle(input string tag, input logic [7:0] exp_after);
        @(negedge clk) busy_in = 1'b1;
        #1;
        expect_item({tag, " R3 busy reads ones"}, S_STATUS, 32'hFF);
        observe();
        @(negedge clk) done_in = 1'b1;
        @(negedge clk) begin done_in = 1'b0; busy_in = 1'b0; end
        #1;
        expect_item({tag, " R5 latch cleared"}, S_STATUS, 32'(exp_after));
        observe();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_run) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 / R2 reset state
        expect_item("R1 reset status", S_STATUS, 32'h00);
        expect_item("R1 reset no lock", S_LANY, 0);
        expect_item("R12 no status write without latch", S_SOK, 0);
        observe();

        // R4 write enable
        txn_chk("R4 write enable", 3'd1, '0, 8'h00, 0, 2'b00, 8'h02);
        expect_item("R12 status write permitted", S_SOK, 1);
        observe();

        // R8 status write loads only bits 7,3:2 ; R2 unused bits stay 0
        txn_chk("R8 status write 0xFF", 3'd3, '0, 8'hFF, 0, 2'b01, 8'h8E);
        write_cycle("R8", 8'h8C);
        expect_item("R6 level 3 lock_lo", S_LOLO, 0);
        expect_item("R6 level 3 lock_any", S_LANY, 1);
        observe();

        // R11 write enable during busy is ignored
        @(negedge clk) busy_in = 1'b1;
        txn_chk("R11 command while busy", 3'd1, '0, 8'h00, 0, 2'b00, 8'hFF);
        @(negedge clk) busy_in = 1'b0;
        #1;
        expect_item("R11 latch unchanged after busy", S_STATUS, 32'h8C);
        observe();

        // R9 hardware protection: pin low, enable 1
        @(negedge clk) wp_n = 1'b0;
        txn_chk("R4 enable with pin low", 3'd1, '0, 8'h00, 0, 2'b00, 8'h8E);
        expect_item("R9 status write not permitted", S_SOK, 0);
        observe();
        txn_chk("R9 status write blocked", 3'd3, '0, 8'h00, 0, 2'b00, 8'h8E);
        txn_chk("R4 disable with pin low", 3'd2, '0, 8'h00, 0, 2'b00, 8'h8C);
        @(negedge clk) wp_n = 1'b1;

        // R10 pin glitch during a selected status write cancels it
        txn_chk("R4 enable again", 3'd1, '0, 8'h00, 0, 2'b00, 8'h8E);
        txn_chk("R10 glitch cancels", 3'd3, '0, 8'h00, 1, 2'b00, 8'h8E);
        txn_chk("R8 status write 0x04", 3'd3, '0, 8'h04, 0, 2'b01, 8'h06);
        write_cycle("R8b", 8'h04);

        // R7 no latch: program rejected
        txn_chk("R7 program without latch", 3'd4, 17'h00000, 8'h00, 0, 2'b00, 8'h04);

        // R6 / R12 level 1 boundary
        txn_chk("R4 enable lvl1", 3'd1, '0, 8'h00, 0, 2'b00, 8'h06);
        expect_item("R6 level 1 lock_lo", S_LOLO, 32'h18000);
        observe();
        @(negedge clk) cmd_addr = 17'h17FFF;
        #1;
        expect_item("R12 below boundary writable", S_AOK, 1);
        observe();
        @(negedge clk) cmd_addr = 17'h18000;
        #1;
        expect_item("R12 boundary locked", S_AOK, 0);
        observe();

        // R7 program locked / unlocked, sector erase locked
        txn_chk("R7 program in locked block", 3'd4, 17'h18010, 8'h00, 0, 2'b00, 8'h06);
        txn_chk("R7 sector erase locked", 3'd5, 17'h1FFFF, 8'h00, 0, 2'b00, 8'h06);
        txn_chk("R7 program unlocked", 3'd4, 17'h08000, 8'h00, 0, 2'b10, 8'h06);
        write_cycle("R7", 8'h04);

        // R9 pin low with enable 0 blocks nothing
        @(negedge clk) wp_n = 1'b0;
        txn_chk("R4 enable pin low en0", 3'd1, '0, 8'h00, 0, 2'b00, 8'h06);
        expect_item("R9 pin ignored when enable 0", S_SOK, 1);
        observe();
        txn_chk("R9 status write with pin low", 3'd3, '0, 8'h08, 0, 2'b01, 8'h0A);
        write_cycle("R9", 8'h08);
        expect_item("R6 level 2 lock_lo", S_LOLO, 32'h10000);
        observe();

        // R7 chip erase refused at level 3, accepted at level 2
        txn_chk("R4 enable lvl2", 3'd1, '0, 8'h00, 0, 2'b00, 8'h0A);
        txn_chk("R7 chip erase level 2", 3'd6, '0, 8'h00, 0, 2'b10, 8'h0A);
        write_cycle("R7c", 8'h08);
        txn_chk("R4 enable", 3'd1, '0, 8'h00, 0, 2'b00, 8'h0A);
        txn_chk("R8 set level 3", 3'd3, '0, 8'h0C, 0, 2'b01, 8'h0E);
        write_cycle("R8c", 8'h0C);
        txn_chk("R4 enable lvl3", 3'd1, '0, 8'h00, 0, 2'b00, 8'h0E);
        txn_chk("R7 chip erase level 3", 3'd6, '0, 8'h00, 0, 2'b00, 8'h0E);
        txn_chk("R7 sector erase at 0 level 3", 3'd5, 17'h00000, 8'h00, 0, 2'b00, 8'h0E);
        @(negedge clk) wp_n = 1'b1;

        repeat (2) @(negedge clk);
        done_run = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule